// File: doc/BRIEF.md
# Clock-Stretching Serial Slave Engine

This block is the slave side of a three-wire synchronous serial link in the style of SPI. The link has a shared clock line, an inbound data line driven by the master, and an outbound data line that the slave can only pull low. The engine oversamples the clock and inbound data lines with its own system clock. It shifts inbound bits in on rising clock edges, most significant bit first, and presents reply bits on falling clock edges. Each received byte appears on a parallel output together with a one-cycle strobe.

After every complete byte the slave acknowledges by holding the shared clock line low for a timed window. It ignores the clock edges that this window causes, so the next byte starts aligned. Reply bytes come from an external source through a valid/take pair. A reply is only taken when a byte begins, so the outbound stream never shifts by part of a byte. The outbound line is also released a fixed time after every sampling edge, which lets the master see the line return high before the next bit.

All delays are whole microseconds. Each delay counts `TICK_DIV` system cycles per microsecond, so the same RTL serves any system clock rate.

Top module: `stretch_serial_slave`

## Requirements
- R1: Each accepted rising edge of the synchronized clock line shifts the synchronized inbound bit in, most significant bit first. On the eighth rising edge the byte is placed on `rx_data_o` with `rx_valid_o` high for exactly one cycle, and the bit count returns to zero. After reset all outputs are low.
- R2: On each accepted falling edge, while a reply is in progress, the next reply bit is presented, starting with bit 7. `lnk_dout_pull_o` is 1 when that bit is 0 and 0 when it is 1.
- R3: `rpl_take_o` pulses for one cycle, and `rpl_data_i` is loaded, only on an accepted falling edge where the bit count is zero, no reply is in progress and `rpl_valid_i` is high.
- R4: If no reply is valid at the falling edge that opens a byte, `lnk_dout_pull_o` stays 0 for that whole byte, even if a reply becomes valid during the byte. That reply is used by the following byte.
- R5: `lnk_dout_pull_o` returns to 0 `REL_US` microseconds after each accepted rising edge. Each new rising edge restarts this timer.
- R6: `ACK_START_US` microseconds after a byte completes, `lnk_clk_pull_o` rises and stays high for `ACK_LOW_US` microseconds.
- R7: While the acknowledge is in progress, clock edges are neither sampled nor used for shifting. This includes the edge when the line is released. The next byte is therefore received whole, and each transfer yields exactly one strobe.
- R8: Completing a byte ends the reply in progress. Each byte uses at most one reply byte, and the next byte fetches a fresh one.
- R9: While `en_i` is low, both pull outputs are 0 in the same cycle. The engine returns to idle, discarding any partial byte, reply in progress or pending delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Engine enable; low forces idle and releases both lines |
| lnk_clk_i | input | 1 | Level of the shared clock line |
| lnk_din_i | input | 1 | Level of the inbound data line |
| lnk_clk_pull_o | output | 1 | 1 pulls the shared clock line low (acknowledge) |
| lnk_dout_pull_o | output | 1 | 1 pulls the outbound data line low |
| rpl_valid_i | input | 1 | A reply byte is available |
| rpl_data_i | input | 8 | Reply byte, held until taken |
| rpl_take_o | output | 1 | One-cycle pulse: reply byte consumed |
| rx_data_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe for a new byte on `rx_data_o` |

## Verification
The assertions check the following on every cycle:
- the strobe lasts exactly one cycle and comes with a cleared bit count;
- a take needs a valid reply and always lands on a byte boundary;
- the clock pull appears only in the acknowledge state, and the bit count stays frozen there;
- a low enable leaves the engine idle.

Some behaviours only the bench scenarios can show, because they depend on the master's waveform:
- bit ordering on both data lines;
- the timing of the release and acknowledge windows against the line edges;
- a reply that arrives mid-byte being deferred to the next byte;
- disabling the engine during a byte or during the acknowledge, then resuming cleanly.

// File: rtl/ssl_pkg.sv
package ssl_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_CW = $clog2(BYTE_W);

    localparam int TMR_REL  = 0;
    localparam int TMR_ACKS = 1;
    localparam int TMR_ACKL = 2;
    localparam int NUM_TMR  = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RECV = 2'd1,
        ST_ACK  = 2'd2
    } lnk_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] shift;
        logic [BIT_CW-1:0] cnt;
    } rx_acc_t;

    typedef struct packed {
        logic              active;
        logic [BYTE_W-1:0] data;
        logic [BIT_CW-1:0] idx;
    } tx_slot_t;

    function automatic logic [BYTE_W-1:0] shift_in(logic [BYTE_W-1:0] v, logic b);
        return {v[BYTE_W-2:0], b};
    endfunction

    function automatic int tmr_len(int idx, int rel_us, int acks_us, int ackl_us);
        case (idx)
            TMR_REL:  return rel_us;
            TMR_ACKS: return acks_us;
            default:  return ackl_us;
        endcase
    endfunction

endpackage

// File: rtl/ssl_sync.sv
module ssl_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a,
    output logic [W-1:0] s
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '1;
        end else begin
            pipe[0] <= a;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign s = pipe[STAGES-1];
endmodule

// File: rtl/ssl_delay.sv
module ssl_delay #(
    parameter int DIV = 125,
    parameter int US  = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic start,
    output logic done
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int UW = (US > 1) ? $clog2(US) : 1;
    localparam logic [PW-1:0] PRE_TOP = PW'(DIV - 1);
    localparam logic [UW-1:0] US_TOP  = UW'(US - 1);

    logic [PW-1:0] pre;
    logic [UW-1:0] cnt;
    logic          busy;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            busy <= 1'b0;
            done <= 1'b0;
            pre  <= '0;
            cnt  <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy <= 1'b1;
                pre  <= PRE_TOP;
                cnt  <= US_TOP;
            end else if (busy) begin
                if (pre == '0) begin
                    pre <= PRE_TOP;
                    if (cnt == '0) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end else begin
                    pre <= pre - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/stretch_serial_slave.sv
module stretch_serial_slave
    import ssl_pkg::*;
#(
    parameter int TICK_DIV     = 125,
    parameter int REL_US       = 5,
    parameter int ACK_START_US = 14,
    parameter int ACK_LOW_US   = 25,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              lnk_clk_i,
    input  logic              lnk_din_i,
    output logic              lnk_clk_pull_o,
    output logic              lnk_dout_pull_o,
    input  logic              rpl_valid_i,
    input  logic [BYTE_W-1:0] rpl_data_i,
    output logic              rpl_take_o,
    output logic [BYTE_W-1:0] rx_data_o,
    output logic              rx_valid_o
);
    localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_W - 1);

    // line synchronizer and edge detection
    logic [1:0] sy;
    logic       clk_s, din_s, clk_prev;

    ssl_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .a   ({lnk_din_i, lnk_clk_i}),
        .s   (sy)
    );
    assign clk_s = sy[0];
    assign din_s = sy[1];

    always_ff @(posedge clk) begin
        if (rst) clk_prev <= 1'b1;
        else     clk_prev <= clk_s;
    end

    lnk_state_e st;
    rx_acc_t    rx_q;
    tx_slot_t   tx_q, tx_d;
    logic       ack_pull_q, dout_pull_q, pull_d;

    logic live, acc_rise, acc_fall, byte_done, fetch_slot;
    assign live       = en_i && (st != ST_ACK);
    assign acc_rise   = live && clk_s && !clk_prev;
    assign acc_fall   = live && !clk_s && clk_prev;
    assign byte_done  = acc_rise && (rx_q.cnt == LAST_BIT);
    assign fetch_slot = acc_fall && !tx_q.active && (rx_q.cnt == '0);
    assign rpl_take_o = fetch_slot && rpl_valid_i;

    // release, acknowledge-start and acknowledge-low timers
    logic [NUM_TMR-1:0] tmr_start, tmr_done;
    assign tmr_start[TMR_REL]  = acc_rise;
    assign tmr_start[TMR_ACKS] = byte_done;
    assign tmr_start[TMR_ACKL] = tmr_done[TMR_ACKS];

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        ssl_delay #(
            .DIV (TICK_DIV),
            .US  (tmr_len(g, REL_US, ACK_START_US, ACK_LOW_US))
        ) u_delay (
            .clk   (clk),
            .rst   (rst),
            .clear (!en_i),
            .start (tmr_start[g]),
            .done  (tmr_done[g])
        );
    end

    // reply slot next-state
    always_comb begin
        tx_d   = tx_q;
        pull_d = dout_pull_q;
        if (tmr_done[TMR_REL]) pull_d = 1'b0;
        if (acc_fall) begin
            if (rpl_take_o) begin
                tx_d.active = 1'b1;
                tx_d.data   = rpl_data_i;
                tx_d.idx    = LAST_BIT;
            end
            if (tx_d.active) begin
                pull_d   = ~tx_d.data[tx_d.idx];
                tx_d.idx = tx_d.idx - 1'b1;
            end else begin
                pull_d = 1'b0;
            end
        end
        if (byte_done) tx_d.active = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            st          <= ST_IDLE;
            rx_q        <= '0;
            tx_q        <= '0;
            ack_pull_q  <= 1'b0;
            dout_pull_q <= 1'b0;
            rx_valid_o  <= 1'b0;
            if (rst) rx_data_o <= '0;
        end else begin
            rx_valid_o  <= 1'b0;
            tx_q        <= tx_d;
            dout_pull_q <= pull_d;

            if (acc_rise) begin
                if (byte_done) begin
                    rx_data_o     <= shift_in(rx_q.shift, din_s);
                    rx_valid_o    <= 1'b1;
                    rx_q.shift    <= '0;
                    rx_q.cnt      <= '0;
                end else begin
                    rx_q.shift    <= shift_in(rx_q.shift, din_s);
                    rx_q.cnt      <= rx_q.cnt + 1'b1;
                end
            end

            case (st)
                ST_IDLE, ST_RECV: begin
                    if (acc_rise || acc_fall) st <= ST_RECV;
                    if (tmr_done[TMR_ACKS]) begin
                        st         <= ST_ACK;
                        ack_pull_q <= 1'b1;
                    end
                end
                ST_ACK: begin
                    if (tmr_done[TMR_ACKL]) ack_pull_q <= 1'b0;
                    if (!ack_pull_q && clk_s && clk_prev) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign lnk_clk_pull_o  = ack_pull_q && en_i;
    assign lnk_dout_pull_o = dout_pull_q && en_i;
endmodule

// File: rtl/ssl_checker.sv
module ssl_checker
    import ssl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              en_i,
    input lnk_state_e        st,
    input logic              ack_pull,
    input logic [BIT_CW-1:0] rx_cnt,
    input logic              tx_active,
    input logic              clk_pull_o,
    input logic              rpl_take_o,
    input logic              rpl_valid_i,
    input logic              rx_valid_o
);
    p_valid_pulse_r1: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |=> !rx_valid_o);

    p_count_clear_r1: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |-> (rx_cnt == '0));

    p_take_needs_valid_r3: assert property (@(posedge clk) disable iff (rst)
        rpl_take_o |-> rpl_valid_i);

    p_take_boundary_r3: assert property (@(posedge clk) disable iff (rst)
        rpl_take_o |=> (tx_active && rx_cnt == '0));

    p_pull_in_ack_r6: assert property (@(posedge clk) disable iff (rst)
        clk_pull_o |-> (st == ST_ACK));

    p_mask_count_r7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ACK) |=> $stable(rx_cnt));

    p_mask_take_r7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ACK) |-> !rpl_take_o);

    p_disable_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (st == ST_IDLE && !ack_pull && !tx_active));
endmodule

bind stretch_serial_slave ssl_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .en_i        (en_i),
    .st          (st),
    .ack_pull    (ack_pull_q),
    .rx_cnt      (rx_q.cnt),
    .tx_active   (tx_q.active),
    .clk_pull_o  (lnk_clk_pull_o),
    .rpl_take_o  (rpl_take_o),
    .rpl_valid_i (rpl_valid_i),
    .rx_valid_o  (rx_valid_o)
);

// File: tb/stretch_serial_slave_bench.sv
`timescale 1ns/1ps
module stretch_serial_slave_bench;
    localparam int DIV   = 4;
    localparam int RELU  = 5;
    localparam int ACKSU = 14;
    localparam int ACKLU = 25;
    localparam int H     = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic m_clk = 1'b1;
    logic m_dat = 1'b1;
    logic line_clk;
    logic clk_pull, dout_pull, rpl_valid, rpl_take, rx_valid;
    logic [7:0] rpl_data, rx_data;

    always #4 clk = ~clk;

    assign line_clk = m_clk & ~clk_pull;

    stretch_serial_slave #(
        .TICK_DIV(DIV), .REL_US(RELU), .ACK_START_US(ACKSU), .ACK_LOW_US(ACKLU)
    ) u_stretch_serial_slave (
        .clk(clk), .rst(rst), .en_i(en),
        .lnk_clk_i(line_clk), .lnk_din_i(m_dat),
        .lnk_clk_pull_o(clk_pull), .lnk_dout_pull_o(dout_pull),
        .rpl_valid_i(rpl_valid), .rpl_data_i(rpl_data), .rpl_take_o(rpl_take),
        .rx_data_o(rx_data), .rx_valid_o(rx_valid)
    );

    // reply source model
    logic [7:0] q [16];
    int q_head = 0;
    int q_tail = 0;
    int take_cnt = 0;
    assign rpl_valid = (q_tail != q_head);
    assign rpl_data  = q[q_head % 16];

    always @(posedge clk) begin
        if (rpl_take) begin
            q_head   <= q_head + 1;
            take_cnt <= take_cnt + 1;
        end
    end

    task automatic push(input logic [7:0] v);
        q[q_tail % 16] = v;
        q_tail = q_tail + 1;
    endtask

    // receive monitor
    logic [7:0] rx_last = 8'h00;
    int rx_seen = 0;
    always @(posedge clk) begin
        if (rx_valid) begin
            rx_last <= rx_data;
            rx_seen <= rx_seen + 1;
        end
    end

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_miso(input bit has, input logic [7:0] r);
        return has ? r : 8'hFF;
    endfunction

    // one byte transfer driven by the master model
    task automatic xfer(input logic [7:0] tx, input bit has_rpl, input logic [7:0] rv,
                        input int late_bit, input logic [7:0] late_val, input bit abort_ack);
        logic [7:0] got = 8'h00;
        int takes0 = take_cnt;
        int seen0  = rx_seen;
        int wait_c, width;
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            m_clk = 1'b0;
            m_dat = tx[i];
            for (int k = 0; k < H; k++) @(negedge clk);
            if (i == late_bit) push(late_val);
            got[i] = ~dout_pull;
            m_clk = 1'b1;
            for (int k = 1; k <= H; k++) begin
                @(negedge clk);
                if (k == 12 && has_rpl && !rv[i])
                    chk(dout_pull == 1'b1, "R5 hold before release", dout_pull, 1);
                if (k == 30)
                    chk(dout_pull == 1'b0, "R5 released after rise", dout_pull, 0);
            end
        end
        chk(got == exp_miso(has_rpl, rv), has_rpl ? "R2 reply bits" : "R4 idle reply",
            got, exp_miso(has_rpl, rv));
        chk(take_cnt - takes0 == (has_rpl ? 1 : 0), "R3 R8 takes per byte",
            take_cnt - takes0, has_rpl ? 1 : 0);
        wait_c = H;
        while (!clk_pull && wait_c < 1000) begin
            @(negedge clk);
            wait_c++;
        end
        chk(wait_c >= ACKSU*DIV+2 && wait_c <= ACKSU*DIV+6, "R6 ack start delay",
            wait_c, ACKSU*DIV+4);
        chk(rx_last == tx, "R1 received byte", rx_last, tx);
        if (abort_ack) begin
            repeat (10) @(negedge clk);
            en = 1'b0;
            #1;
            chk(clk_pull == 1'b0, "R9 ack pull released on disable", clk_pull, 0);
            repeat (6) @(negedge clk);
            en = 1'b1;
        end else begin
            width = 0;
            while (clk_pull && width < 1000) begin
                @(negedge clk);
                width++;
            end
            chk(width >= ACKLU*DIV-1 && width <= ACKLU*DIV+3, "R6 ack low width",
                width, ACKLU*DIV+1);
        end
        repeat (8) @(negedge clk);
        chk(rx_seen - seen0 == 1, "R7 one strobe per transfer", rx_seen - seen0, 1);
    endtask

    initial begin
        logic [7:0] tx, rv;
        bit has;
        void'($urandom(32'h1234ABCD));
        repeat (5) @(negedge clk);
        chk(clk_pull == 0 && dout_pull == 0 && rx_valid == 0 && rpl_take == 0,
            "R1 reset outputs", {clk_pull, dout_pull, rx_valid, rpl_take}, 0);
        rst = 1'b0;
        en  = 1'b1;
        repeat (5) @(negedge clk);

        // directed: fixed patterns
        push(8'hAA);
        xfer(8'h0A, 1, 8'hAA, -1, 8'h00, 0);
        push(8'h00);
        xfer(8'hFF, 1, 8'h00, -1, 8'h00, 0);
        xfer(8'h00, 0, 8'h00, -1, 8'h00, 0);

        // random transfers
        for (int n = 0; n < 10; n++) begin
            tx  = 8'($urandom);
            rv  = 8'($urandom);
            has = ($urandom % 4) != 0;
            if (has) push(rv);
            xfer(tx, has, rv, -1, 8'h00, 0);
        end

        // R4: reply arrives mid-byte, used by next byte only
        xfer(8'h3C, 0, 8'h00, 4, 8'h5A, 0);
        xfer(8'hC3, 1, 8'h5A, -1, 8'h00, 0);

        // R8: two queued replies, one per byte
        push(8'h12);
        push(8'h81);
        xfer(8'h77, 1, 8'h12, -1, 8'h00, 0);
        xfer(8'h88, 1, 8'h81, -1, 8'h00, 0);

        // R9: disable mid-byte while pulling data low
        push(8'h00);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            m_clk = 1'b0;
            m_dat = 1'b1;
            repeat (H) @(negedge clk);
            m_clk = 1'b1;
            repeat (H) @(negedge clk);
        end
        @(negedge clk);
        m_clk = 1'b0;
        repeat (H) @(negedge clk);
        chk(dout_pull == 1'b1, "R2 zero bit pulls line", dout_pull, 1);
        en = 1'b0;
        #1;
        chk(dout_pull == 1'b0, "R9 data pull released on disable", dout_pull, 0);
        @(negedge clk);
        m_clk = 1'b1;
        repeat (8) @(negedge clk);
        en = 1'b1;
        repeat (4) @(negedge clk);
        xfer(8'hA5, 0, 8'h00, -1, 8'h00, 0);

        // R9: disable during acknowledge, then resume
        push(8'h66);
        xfer(8'h1E, 1, 8'h66, -1, 8'h00, 1);
        xfer(8'hE1, 0, 8'h00, -1, 8'h00, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule